// File: doc/BRIEF.md
# Three-Bit Direction and Mode Controlled Counter

This block holds a 3-bit count that advances by one on every rising clock edge. A direction control chooses between stepping up and stepping down. A mode control chooses what happens at the end of the range: the count either rolls over to the opposite end, or it stops at the end it has reached.

The block is a Moore machine. Its output is the stored count and nothing else, so the output changes only at a clock edge and never follows the control inputs between edges. Both controls are sampled at every edge and act on the next state. A synchronous active-high reset returns the count to zero.

Top module: `updn_sat_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 on that edge.
- R2: With `dir_down`=0 and the count below 7, each edge raises the count by 1.
- R3: With `dir_down`=1 and the count above 0, each edge lowers the count by 1.
- R4: With `hold_ends`=0, counting up from 7 gives 0 and counting down from 0 gives 7.
- R5: With `hold_ends`=1, the count stays at 7 while counting up and stays at 0 while counting down.
- R6: If the direction reverses while the count is held at an end value, the count leaves that end on the next edge (7 to 6, or 0 to 1).
- R7: `count` changes only at rising clock edges. Changing `dir_down` or `hold_ends` between edges does not change `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| hold_ends | input | 1 | 0 rolls over at the ends, 1 stops at the ends |
| count | output | 3 | Registered count, 0 to 7 |

## Verification
The bench drives the count into both end values under each of the four control combinations. It checks that wrap mode rolls over and that saturate mode holds. A design with an off-by-one end test would roll over or stop at 6 or 1. A design that ignored the mode input would wrap past the end in saturate mode.

The bench also reverses the direction while the count is pinned at 7 or 0. A design that stays latched in a "held" state would fail to step away from the end. The controls are toggled between edges as well, and a design whose output followed the inputs combinationally would show a changed count without a clock edge.

// File: rtl/updn_sat_counter.sv
module updn_sat_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_down,
  input  logic         hold_ends,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] q;
  logic         at_end;
  logic [W-1:0] stepped;

  assign at_end  = dir_down ? (q == BOT) : (q == TOP);
  assign stepped = dir_down ? q - 1'b1 : q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                   q <= BOT;
    else if (at_end && hold_ends) q <= q;
    else                       q <= stepped;
  end

  assign count = q;
endmodule

// File: rtl/updn_sat_counter_chk.sv
module updn_sat_counter_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_down,
  input logic         hold_ends,
  input logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  a_r1_reset_zero: assert property (@(posedge clk) seen && rst |=> count == '0);
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst || !seen)
    !dir_down && count != TOP |=> rst || count == $past(count) + 1'b1);
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst || !seen)
    dir_down && count != '0 |=> rst || count == $past(count) - 1'b1);
  a_r4_wrap_top: assert property (@(posedge clk) disable iff (rst || !seen)
    !hold_ends && !dir_down && count == TOP |=> rst || count == '0);
  a_r4_wrap_bot: assert property (@(posedge clk) disable iff (rst || !seen)
    !hold_ends && dir_down && count == '0 |=> rst || count == TOP);
  a_r5_sat_top: assert property (@(posedge clk) disable iff (rst || !seen)
    hold_ends && !dir_down && count == TOP |=> rst || count == TOP);
  a_r5_sat_bot: assert property (@(posedge clk) disable iff (rst || !seen)
    hold_ends && dir_down && count == '0 |=> rst || count == '0);
endmodule

bind updn_sat_counter updn_sat_counter_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .dir_down(dir_down), .hold_ends(hold_ends), .count(count)
);

// File: tb/updn_sat_counter_tb_top.sv
`timescale 1ns/1ps
module updn_sat_counter_tb_top;
  logic clk = 0, rst = 1, dir_down = 0, hold_ends = 0;
  logic [2:0] count;
  int checks = 0, fails = 0;
  int model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updn_sat_counter dut_i (.clk(clk), .rst(rst), .dir_down(dir_down),
                          .hold_ends(hold_ends), .count(count));

  task automatic chk(input string req, input int exp);
    checks++;
    if (int'(count) != exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  // one edge; model follows requirements, compare 1ns after edge
  task automatic step(input bit d, input bit h, input string req);
    dir_down = d; hold_ends = h;
    @(posedge clk);
    if (rst) model = 0;
    else if (!d) model = (model == 7) ? (h ? 7 : 0) : model + 1;
    else         model = (model == 0) ? (h ? 0 : 7) : model - 1;
    #1 chk(req, model);
  endtask

  task automatic do_reset();
    rst = 1; @(posedge clk); #1; model = 0; chk("R1", 0);
    rst = 0;
  endtask

  task automatic t_wrap_up();
    do_reset();
    for (int i = 0; i < 7; i++) step(0, 0, "R2");
    chk("R2", 7);
    step(0, 0, "R4"); chk("R4", 0);
  endtask

  task automatic t_wrap_down();
    do_reset();
    step(1, 0, "R4"); chk("R4", 7);
    for (int i = 0; i < 7; i++) step(1, 0, "R3");
    chk("R3", 0);
  endtask

  task automatic t_sat_up();
    do_reset();
    for (int i = 0; i < 10; i++) step(0, 1, "R5");
    chk("R5", 7);
    step(1, 1, "R6"); chk("R6", 6);
  endtask

  task automatic t_sat_down();
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 1, "R5");
    chk("R5", 0);
    step(0, 1, "R6"); chk("R6", 1);
  endtask

  task automatic t_mode_switch_at_end();
    do_reset();
    for (int i = 0; i < 7; i++) step(0, 1, "R2");
    step(0, 1, "R5");
    step(0, 0, "R4"); chk("R4", 0);
    step(1, 1, "R5"); chk("R5", 0);
    step(1, 0, "R4"); chk("R4", 7);
  endtask

  task automatic t_no_edge_change();
    do_reset();
    step(0, 0, "R2"); step(0, 0, "R2");
    #0.5 dir_down = 1; #0.3 hold_ends = 1; #0.3 dir_down = 0;
    checks++;
    if (count !== 3'd2) begin
      fails++;
      $display("FAIL R7: count=%0d expected=2", count);
    end
    step(1, 0, "R3"); chk("R3", 1);
    rst = 1; step(0, 0, "R1"); rst = 0; chk("R1", 0);
  endtask

  initial begin
    #1;
    t_wrap_up();
    t_wrap_down();
    t_sat_up();
    t_sat_down();
    t_mode_switch_at_end();
    t_no_edge_change();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule